// File: doc/BRIEF.md
# Legacy Wire-Interrupt Message Router

This block sits behind a downstream port and receives in-band legacy interrupt messages. Each message names one of several virtual interrupt wires and says whether that wire is being raised or dropped. The router keeps a level bit for every wire. It sends each event to one of two places, or to neither. It can convert the event into a message-signalled interrupt, using a per-wire redirection entry that holds a 32-bit address and a 32-bit data word. It can instead pass the raise or drop unchanged to a legacy sideband output that leads to a downstream interrupt hub. Or it can drop the event.

Two controls decide the route: the wire's mask bit in the redirection table, and one global forwarding-off bit. A clear mask bit means conversion. A set mask bit means legacy forwarding, but only while the forwarding-off bit is 0. When both bits are set, the event has no effect. Both outputs use valid/ready handshakes. Events that arrive while an output is stalled are held per wire, so raises and drops toward the hub stay balanced. A write-only register port programs the controls and the table.

Top module: `intx_msg_router`

## Requirements
- R1: After reset, no output is valid, every wire level is low, every mask bit is 1 and the forwarding-off bit is 0. A raise that arrives before any register write is therefore forwarded on the legacy output.
- R2: If a wire is low and its mask bit is 0, a raise on it presents one conversion on the MSI output in the cycle after the message. That output carries the wire index and the entry's address and data words.
- R3: A raise on a wire that is already high produces no further conversion and no further legacy message.
- R4: If the mask bit is 1 and the forwarding-off bit is 0, a raise is sent on the legacy output with `leg_assert`=1, and a later drop is sent with `leg_assert`=0. Both carry the wire index and appear in the cycle after the message.
- R5: If the mask bit is 1 and the forwarding-off bit is 1, a raise on a low wire produces no output at all.
- R6: If the mask bit is 0 and the forwarding-off bit is 1, a raise is still converted and nothing appears on the legacy output.
- R7: A drop is forwarded whenever the last raise the legacy side was sent has not yet been followed by a drop. This holds even if the mask bit or the forwarding-off bit changed while the wire was high.
- R8: Writing a 0 into the mask bit of a wire that is high produces exactly one conversion for that wire, visible in the cycle after the write.
- R9: A valid output holds until it is accepted. Each wire holds one pending conversion and up to two pending legacy transitions. A third transition merges the oldest unsent drop/raise pair, so the final forwarded level always matches the wire level.
- R10: When several wires have work pending on the same output, the lowest wire index is presented first.
- R11: Register map for `cfg_addr`: address 0 bit 0 is the forwarding-off bit. Address 1 bit i is the mask of wire i. Address 8+2i is entry i's MSI address and 9+2i is its data word. A write takes effect at the next clock edge, and the data word shown is the one current while the conversion waits.
- R12: A raise and a write that clears the same wire's mask in one cycle are judged against the old mask bit. The raise is forwarded on the legacy output, and the mask change also produces a conversion, so both outputs become valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_wire | input | WW | Virtual wire addressed by the message |
| msg_is_assert | input | 1 | 1 = raise, 0 = drop |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 32 | Register write data |
| msi_valid | output | 1 | Conversion output valid |
| msi_ready | input | 1 | Conversion output accepted |
| msi_index | output | WW | Redirection entry index |
| msi_addr | output | 32 | Entry's MSI address word |
| msi_data | output | 32 | Entry's MSI data word |
| leg_valid | output | 1 | Legacy sideband message valid |
| leg_ready | input | 1 | Legacy sideband message accepted |
| leg_wire | output | WW | Wire carried by the legacy message |
| leg_assert | output | 1 | 1 = raise, 0 = drop on the legacy side |

## Verification
Two functions can fall in one cycle: routing a raise and the mask-clear write on the same wire. The bench drives a message and a register write on the same clock. It expects the raise to go out on the legacy output under the old mask, and the write to add a conversion, so both outputs are valid one cycle later. A second overlap is a new event arriving while an output takes an earlier one for another wire. Stalls of each ready input provoke this, and the order of accepted messages is compared against lowest-index-first.

// File: rtl/intx_rt_pkg.sv
package intx_rt_pkg;
   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t addr;
      word_t data;
   } msi_entry_t;

   // legacy transitions a wire may hold while its output stalls
   localparam int unsigned LEG_DEPTH = 2;
endpackage

// File: rtl/intx_rt_regs.sv
module intx_rt_regs
   import intx_rt_pkg::*;
#(
   parameter int unsigned NUM_WIRES = 4,
   parameter int unsigned AW        = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [AW-1:0]                  addr,
   input  word_t                          wdata,
   output logic                           fwd_off,
   output logic [NUM_WIRES-1:0]           mask,
   output logic [NUM_WIRES-1:0]           mask_clr,
   output msi_entry_t [NUM_WIRES-1:0]     entries
);
   localparam int unsigned IW = AW - 2;

   logic ctrl_hit;
   logic mask_hit;

   assign ctrl_hit = wr && (addr == AW'(0));
   assign mask_hit = wr && (addr == AW'(1));
   assign mask_clr = mask_hit ? (mask & ~wdata[NUM_WIRES-1:0]) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_off <= 1'b0;
         mask    <= '1;
      end else begin
         if (ctrl_hit) fwd_off <= wdata[0];
         if (mask_hit) mask    <= wdata[NUM_WIRES-1:0];
      end
   end

   for (genvar e = 0; e < NUM_WIRES; e++) begin : g_entry
      logic hit;
      assign hit = wr && addr[AW-1] && (addr[AW-2:1] == IW'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entries[e] <= '0;
         end else if (hit) begin
            if (addr[0]) entries[e].data <= wdata;
            else         entries[e].addr <= wdata;
         end
      end
   end

   // R11: control write visible after the next edge
   p_ctrl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (fwd_off == $past(wdata[0])));
   // R11: mask write visible after the next edge
   p_mask_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_hit |=> (mask == $past(wdata[NUM_WIRES-1:0])));
endmodule

// File: rtl/intx_rt_wire.sv
module intx_rt_wire
   import intx_rt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic ev_assert,
   input  logic mask,
   input  logic mask_clr,
   input  logic fwd_off,
   input  logic msi_take,
   input  logic leg_take,
   output logic msi_pend,
   output logic leg_pend,
   output logic leg_bit
);
   logic       level_q;
   logic       msi_q;
   logic       sent_q;
   logic [1:0] owed_q;

   logic       tgt;
   logic       rise, fall, level_d;
   logic       fwd_raise, fwd_drop, toggle;
   logic [1:0] owed_left, owed_d;
   logic       msi_set;

   assign tgt       = sent_q ^ owed_q[0];
   assign rise      = ev &  ev_assert & ~level_q;
   assign fall      = ev & ~ev_assert &  level_q;
   assign level_d   = rise | (level_q & ~fall);
   assign fwd_raise = rise & mask & ~fwd_off & ~tgt;
   assign fwd_drop  = ev & ~ev_assert & tgt;
   assign toggle    = fwd_raise | fwd_drop;
   assign owed_left = owed_q - {1'b0, leg_take};

   always_comb begin
      owed_d = owed_left;
      if (toggle) begin
         if (owed_left == 2'(LEG_DEPTH)) owed_d = 2'(LEG_DEPTH - 1);
         else                            owed_d = owed_left + 2'd1;
      end
   end

   assign msi_set = (rise & ~mask) | (mask_clr & level_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         msi_q   <= 1'b0;
         sent_q  <= 1'b0;
         owed_q  <= 2'd0;
      end else begin
         level_q <= level_d;
         msi_q   <= msi_set | (msi_q & ~msi_take);
         sent_q  <= sent_q ^ leg_take;
         owed_q  <= owed_d;
      end
   end

   assign msi_pend = msi_q;
   assign leg_pend = (owed_q != 2'd0);
   assign leg_bit  = ~sent_q;

   // R3: a raise on a high wire changes neither pending state
   p_repeat_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && ev_assert && level_q && !mask_clr && !msi_take && !leg_take)
      |=> ($stable(msi_q) && $stable(owed_q)));
   // R5: masked raise with forwarding off is dropped
   p_drop_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && ev_assert && mask && fwd_off && !mask_clr && !msi_take && !leg_take)
      |=> ($stable(msi_q) && $stable(owed_q)));
   // R7: a drop after a forwarded raise always lowers the legacy target
   p_drop_forwarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !ev_assert && tgt) |=> ((sent_q ^ owed_q[0]) == 1'b0));
   // R9: legacy hold never exceeds its depth
   p_leg_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q <= 2'(LEG_DEPTH));
endmodule

// File: rtl/intx_rt_pick.sv
module intx_rt_pick #(
   parameter int unsigned N         = 4,
   parameter int unsigned WW        = 2,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [WW-1:0] idx
);
   assign any = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = WW'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) idx = WW'(i);
         end
      end
   end
endmodule

// File: rtl/intx_msg_router.sv
module intx_msg_router
   import intx_rt_pkg::*;
#(
   parameter int unsigned NUM_WIRES = 4,
   localparam int unsigned WW = $clog2(NUM_WIRES),
   localparam int unsigned AW = WW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          msg_valid,
   input  logic [WW-1:0] msg_wire,
   input  logic          msg_is_assert,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic          msi_valid,
   input  logic          msi_ready,
   output logic [WW-1:0] msi_index,
   output logic [31:0]   msi_addr,
   output logic [31:0]   msi_data,
   output logic          leg_valid,
   input  logic          leg_ready,
   output logic [WW-1:0] leg_wire,
   output logic          leg_assert
);
   if (NUM_WIRES < 2 || NUM_WIRES > 16) begin : g_bad_cfg
      $error("intx_msg_router: NUM_WIRES must lie in 2..16");
   end

   logic                       fwd_off;
   logic [NUM_WIRES-1:0]       mask, mask_clr;
   msi_entry_t [NUM_WIRES-1:0] entries;
   logic [NUM_WIRES-1:0]       ev, msi_pend, leg_pend, leg_bit;
   logic [NUM_WIRES-1:0]       msi_take, leg_take;

   intx_rt_regs #(.NUM_WIRES(NUM_WIRES), .AW(AW)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .fwd_off(fwd_off), .mask(mask), .mask_clr(mask_clr), .entries(entries)
   );

   for (genvar i = 0; i < NUM_WIRES; i++) begin : g_wire
      assign ev[i]       = msg_valid && (msg_wire == WW'(i));
      assign msi_take[i] = msi_valid && msi_ready && (msi_index == WW'(i));
      assign leg_take[i] = leg_valid && leg_ready && (leg_wire == WW'(i));

      intx_rt_wire wire_i (
         .clk(clk), .rst_n(rst_n), .ev(ev[i]), .ev_assert(msg_is_assert),
         .mask(mask[i]), .mask_clr(mask_clr[i]), .fwd_off(fwd_off),
         .msi_take(msi_take[i]), .leg_take(leg_take[i]),
         .msi_pend(msi_pend[i]), .leg_pend(leg_pend[i]), .leg_bit(leg_bit[i])
      );
   end

   intx_rt_pick #(.N(NUM_WIRES), .WW(WW), .LOW_FIRST(1'b1)) msi_pick_i (
      .req(msi_pend), .any(msi_valid), .idx(msi_index)
   );
   intx_rt_pick #(.N(NUM_WIRES), .WW(WW), .LOW_FIRST(1'b1)) leg_pick_i (
      .req(leg_pend), .any(leg_valid), .idx(leg_wire)
   );

   assign msi_addr   = entries[msi_index].addr;
   assign msi_data   = entries[msi_index].data;
   assign leg_assert = leg_bit[leg_wire];

   // R9: stalled outputs keep their valid
   p_msi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && !msi_ready) |=> msi_valid);
   p_leg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_valid && !leg_ready) |=> leg_valid);
   // R10: no lower-index wire waits behind the presented one
   p_msi_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid |-> ((msi_pend & ((NUM_WIRES'(1) << msi_index) - NUM_WIRES'(1))) == '0));
   p_leg_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      leg_valid |-> ((leg_pend & ((NUM_WIRES'(1) << leg_wire) - NUM_WIRES'(1))) == '0));
   // R1: outputs idle in the first cycle after reset
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!msi_valid && !leg_valid));
endmodule

// File: tb/intx_msg_router_tb_top.sv
module intx_msg_router_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [1:0]  msg_wire = '0;
   logic        msg_is_assert = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        msi_valid, leg_valid, leg_assert;
   logic        msi_ready = 1'b1;
   logic        leg_ready = 1'b1;
   logic [1:0]  msi_index, leg_wire;
   logic [31:0] msi_addr, msi_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   intx_msg_router #(.NUM_WIRES(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_wire(msg_wire),
      .msg_is_assert(msg_is_assert), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .msi_valid(msi_valid), .msi_ready(msi_ready),
      .msi_index(msi_index), .msi_addr(msi_addr), .msi_data(msi_data),
      .leg_valid(leg_valid), .leg_ready(leg_ready), .leg_wire(leg_wire),
      .leg_assert(leg_assert)
   );

   function automatic logic [31:0] exp_data(int w);
      return 32'h0000_4000 + 32'(w) * 32'h11;
   endfunction
   function automatic logic [31:0] exp_addr(int w);
      return 32'hFEE0_0000 + (32'(w) << 12);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic send(input int w, input logic a);
      msg_valid = 1'b1; msg_wire = 2'(w); msg_is_assert = a;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send_and_wr(input int w, input logic a,
                              input logic [3:0] ra, input logic [31:0] d);
      msg_valid = 1'b1; msg_wire = 2'(w); msg_is_assert = a;
      cfg_wr = 1'b1; cfg_addr = ra; cfg_wdata = d;
      @(negedge clk);
      msg_valid = 1'b0; cfg_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      string tg;
      logic mb, off, exp_m, exp_l;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 msi_valid idle", 32'(msi_valid), 32'd0);
      chk("R1 leg_valid idle", 32'(leg_valid), 32'd0);
      send(0, 1'b1);
      chk("R1 default forward valid", 32'(leg_valid), 32'd1);
      chk("R1 default forward wire", 32'(leg_wire), 32'd0);
      chk("R1 default forward raise", 32'(leg_assert), 32'd1);
      chk("R1 default no msi", 32'(msi_valid), 32'd0);
      send(0, 1'b0);
      chk("R1 default forward drop", 32'(leg_assert), 32'd0);
      step();

      // R11: program table, address 8+2i / 9+2i
      for (int w = 0; w < 4; w++) begin
         wr_reg(4'(8 + 2 * w), exp_addr(w));
         wr_reg(4'(9 + 2 * w), exp_data(w));
      end

      // Sweep of all wires over all mask/forward-off combinations
      for (int w = 0; w < 4; w++) begin
         for (int c = 0; c < 4; c++) begin
            mb = c[0]; off = c[1];
            exp_m = !mb; exp_l = mb && !off;
            tg = !mb ? (off ? "R6" : "R2") : (off ? "R5" : "R4");
            wr_reg(4'h0, {31'b0, off});
            wr_reg(4'h1, mb ? 32'hF : (32'hF & ~(32'h1 << w)));
            send(w, 1'b1);
            chk({tg, " raise msi_valid"}, 32'(msi_valid), 32'(exp_m));
            chk({tg, " raise leg_valid"}, 32'(leg_valid), 32'(exp_l));
            if (exp_m) begin
               chk({tg, " msi_index"}, 32'(msi_index), 32'(w));
               chk({tg, " msi_addr"}, msi_addr, exp_addr(w));
               chk({tg, " msi_data"}, msi_data, exp_data(w));
            end
            if (exp_l) begin
               chk({tg, " leg_wire"}, 32'(leg_wire), 32'(w));
               chk({tg, " leg_assert"}, 32'(leg_assert), 32'd1);
            end
            step();
            chk({tg, " drained"}, 32'({msi_valid, leg_valid}), 32'd0);
            send(w, 1'b1);
            chk("R3 repeat raise silent", 32'({msi_valid, leg_valid}), 32'd0);
            send(w, 1'b0);
            chk({tg, " drop msi none"}, 32'(msi_valid), 32'd0);
            chk({tg, " drop leg_valid"}, 32'(leg_valid), 32'(exp_l));
            if (exp_l) chk({tg, " drop leg_assert"}, 32'(leg_assert), 32'd0);
            step();
         end
      end

      // R7 / R8: forwarded raise, then controls change while high
      wr_reg(4'h0, 32'h0);
      wr_reg(4'h1, 32'hF);
      send(1, 1'b1);
      chk("R4 raise w1 forwarded", 32'({leg_valid, leg_wire, leg_assert}), 32'b1011);
      step();
      wr_reg(4'h0, 32'h1);
      wr_reg(4'h1, 32'hD);
      chk("R8 unmask while high msi_valid", 32'(msi_valid), 32'd1);
      chk("R8 unmask while high index", 32'(msi_index), 32'd1);
      chk("R8 unmask while high data", msi_data, exp_data(1));
      step();
      chk("R8 single conversion", 32'(msi_valid), 32'd0);
      send(1, 1'b0);
      chk("R7 drop still forwarded", 32'({leg_valid, leg_wire, leg_assert}), 32'b1010);
      chk("R7 no msi on drop", 32'(msi_valid), 32'd0);
      step();

      // R9: legacy stall holds raise then drop
      wr_reg(4'h0, 32'h0);
      wr_reg(4'h1, 32'hF);
      leg_ready = 1'b0;
      send(2, 1'b1);
      send(2, 1'b0);
      step(); step();
      chk("R9 stalled raise held", 32'({leg_valid, leg_wire, leg_assert}), 32'b1101);
      leg_ready = 1'b1;
      step();
      chk("R9 drop follows raise", 32'({leg_valid, leg_wire, leg_assert}), 32'b1100);
      step();
      chk("R9 legacy drained", 32'(leg_valid), 32'd0);
      // R9: third transition merges the drop/raise pair
      leg_ready = 1'b0;
      send(2, 1'b1); send(2, 1'b0); send(2, 1'b1);
      chk("R9 merged head raise", 32'({leg_valid, leg_wire, leg_assert}), 32'b1101);
      leg_ready = 1'b1;
      step();
      chk("R9 merge leaves level high", 32'(leg_valid), 32'd0);
      send(2, 1'b0);
      chk("R9 final drop", 32'({leg_valid, leg_wire, leg_assert}), 32'b1100);
      step();

      // R10: legacy lowest index first
      leg_ready = 1'b0;
      send(3, 1'b1);
      send(1, 1'b1);
      chk("R10 legacy low index first", 32'(leg_wire), 32'd1);
      leg_ready = 1'b1;
      step();
      chk("R10 legacy then w3", 32'({leg_valid, leg_wire, leg_assert}), 32'b1111);
      step();
      send(3, 1'b0);
      chk("R4 w3 drop", 32'({leg_valid, leg_wire, leg_assert}), 32'b1110);
      send(1, 1'b0);
      chk("R4 w1 drop", 32'({leg_valid, leg_wire, leg_assert}), 32'b1010);
      step();

      // R10 / R11: MSI ordering and data sampled while waiting
      wr_reg(4'h1, 32'h6);
      msi_ready = 1'b0;
      send(3, 1'b1);
      chk("R9 msi w3 pending", 32'({msi_valid, msi_index}), 32'b111);
      send(0, 1'b1);
      chk("R10 msi low index first", 32'({msi_valid, msi_index}), 32'b100);
      wr_reg(4'h9, 32'hCAFE_0000);
      chk("R11 data rewrite visible", msi_data, 32'hCAFE_0000);
      msi_ready = 1'b1;
      step();
      chk("R10 msi then w3", 32'({msi_valid, msi_index}), 32'b111);
      chk("R10 msi w3 data", msi_data, exp_data(3));
      step();
      chk("R9 msi drained", 32'(msi_valid), 32'd0);
      wr_reg(4'h9, exp_data(0));
      send(3, 1'b0);
      send(0, 1'b0);
      chk("R2 unmasked drop silent", 32'({msi_valid, leg_valid}), 32'd0);

      // R12: raise and mask-clear write in the same cycle
      wr_reg(4'h1, 32'hF);
      send_and_wr(2, 1'b1, 4'h1, 32'hB);
      chk("R12 legacy raise under old mask", 32'({leg_valid, leg_wire, leg_assert}), 32'b1101);
      chk("R12 conversion from mask clear", 32'({msi_valid, msi_index}), 32'b110);
      step();
      chk("R12 both drained", 32'({msi_valid, leg_valid}), 32'd0);
      send(2, 1'b0);
      chk("R12 drop forwarded", 32'({leg_valid, leg_wire, leg_assert}), 32'b1100);
      step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule